// File: doc/BRIEF.md
# Sensor Register Table Loader

This block brings an image sensor into a known state after power-up. It holds a table of register-index and value pairs in a computed ROM. On a start pulse it reads the table from entry 0 upward and writes each pair to the sensor over a two-wire bus. The bus is I2C-style and the block is always its master. Each pair becomes one write transaction, made of the device address, the register index and the value. The slave must acknowledge every byte.

The block drives SCL directly. It controls SDA open-drain style: `sda_oe` high pulls the line low, and `sda_in` returns the line level. When the block reaches an entry whose index and value are both 0xFF, it stops and raises `done`. If any byte goes unacknowledged, the block closes the bus with a stop condition and raises `error`. The outcome flags hold until the next start pulse.

Top module: `sensor_cfg_master`

## Requirements
- R1: After reset the block is idle. In the idle state SCL is high, SDA is released (`sda_oe`=0), and `busy`, `done` and `error` are all 0.
- R2: A one-cycle `start` while idle raises `busy` on the next clock and clears `done` and `error`. A `start` while `busy` is high is ignored and does not begin a new table walk.
- R3: Every table entry is sent as one transaction in this order: a start condition, the device address `DEV_ADDR` (default 0x42), the register index, the value, and a stop condition. Each byte is sent MSB first and is followed by one acknowledge slot in which SDA is released. The slave acknowledges by holding SDA low.
- R4: The table is walked in order from entry 0. Entry i, for i < `LIVE`, holds register index 0x20+i and value 0x5A xor i. Entry `LIVE` is the end marker 0xFF/0xFF.
- R5: The end marker produces no bus traffic. When it is reached, `busy` drops and `done`=1 with `error`=0.
- R6: Each SCL high phase and each SCL low phase during a bit lasts 2·Q clock cycles, where Q = CLK_HZ/(4·SCL_HZ). The default setting gives 100 kHz.
- R7: SDA changes while SCL is high only for a start condition (SDA falls) or a stop condition (SDA rises). Data bits change only while SCL is low.
- R8: If any acknowledge slot is found high (no acknowledge), no further byte of that transaction is sent. The block issues a stop condition, starts no further transaction, and ends with `error`=1, `done`=0 and `busy`=0.
- R9: `done` and `error` keep their values while idle until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to walk the table |
| scl | output | 1 | Serial clock to the sensor |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level on the SDA line |
| busy | output | 1 | Table walk in progress |
| done | output | 1 | Last walk reached the end marker |
| error | output | 1 | Last walk stopped on a missing acknowledge |

## Verification
A wrong table index or a wrong byte counter shows at the ports within one transaction. The decoded register and value bytes no longer match the arithmetic table, or the number of start and stop conditions differs from the number of entries. A bad bit or phase counter shows within one SCL period, either as a wrong SCL high or low width or as a spurious start or stop condition seen while SCL is high. A mishandled acknowledge shows in the sweep that refuses each byte of each transaction in turn. There it appears as extra transactions after the refusal, a missing stop, or the wrong outcome flag at the end of the walk.

// File: rtl/scfg_pkg.sv
// Shared types for the sensor register table loader.
package scfg_pkg;

    // One table entry: target register index and the value written to it
    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] val;
    } cfg_pair_t;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_START,
        ST_BIT,
        ST_STOP
    } seq_state_t;

    localparam logic [7:0] END_MARK = 8'hFF;

endpackage

// File: rtl/scfg_rom.sv
// Computed configuration table.
// Assumes: idx is below or equal to the table depth; entries at LIVE and
// beyond read as the end marker.
module scfg_rom
    import scfg_pkg::*;
#(
    parameter int DEPTH = 150,
    parameter int LIVE  = 149,
    parameter int IW    = 8
) (
    input  logic [IW-1:0] idx,
    output cfg_pair_t     entry
);
    logic [7:0] i8;

    // Low byte of the index drives the arithmetic contents
    always_comb begin
        i8 = 8'(idx);
    end

    // Table lookup: live entries are arithmetic, the rest is the end marker
    always_comb begin
        if (int'(idx) < LIVE && int'(idx) < DEPTH) begin
            entry.idx = 8'h20 + i8;
            entry.val = 8'h5A ^ i8;
        end else begin
            entry.idx = END_MARK;
            entry.val = END_MARK;
        end
    end
endmodule

// File: rtl/scfg_tick.sv
// Quarter-bit strobe generator for the serial clock.
// Assumes: QTR >= 2. The count restarts whenever en is low.
module scfg_tick #(
    parameter int QTR = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR - 1);

    logic [CW-1:0] cnt;

    // Modulo-QTR counter, held at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en)    cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    // One-cycle strobe at the end of each quarter
    always_comb begin
        tick = en && (cnt == LAST);
    end
endmodule

// File: rtl/scfg_sync.sv
// Two-stage synchroniser for the SDA return line.
// Assumes: the line idles high, so the reset value is 1.
module scfg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1;

    // Shift the asynchronous level through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            q  <= 1'b1;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/sensor_cfg_master.sv
// Walks the configuration table and writes each pair to the sensor as a
// three-byte bus write. Every bit takes four quarter ticks: the data is
// set, SCL rises, the line is sampled, SCL falls.
// Assumes: single master, open-drain SDA with an external pull-up,
// synchronous active-low reset.
module sensor_cfg_master
    import scfg_pkg::*;
#(
    parameter int         CLK_HZ   = 50_000_000,
    parameter int         SCL_HZ   = 100_000,
    parameter logic [7:0] DEV_ADDR = 8'h42,
    parameter int         DEPTH    = 150,
    parameter int         LIVE     = 149
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic scl,
    output logic sda_oe,
    input  logic sda_in,
    output logic busy,
    output logic done,
    output logic error
);
    localparam int QTR = CLK_HZ / (4 * SCL_HZ);
    localparam int IW  = $clog2(DEPTH + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH);

    seq_state_t    state;
    logic [1:0]    phase;
    logic [3:0]    bitn;
    logic [1:0]    bytn;
    logic [7:0]    shreg;
    logic [IW-1:0] idx;
    cfg_pair_t     entry;
    cfg_pair_t     cur;
    logic          abort;
    logic          tick;
    logic          sda_s;

    scfg_rom #(.DEPTH(DEPTH), .LIVE(LIVE), .IW(IW)) u_rom (
        .idx   (idx),
        .entry (entry)
    );

    scfg_tick #(.QTR(QTR)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .tick  (tick)
    );

    scfg_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sda_in),
        .q     (sda_s)
    );

    // Sequencer: table walk, framing, bit timing and acknowledge check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            phase  <= '0;
            bitn   <= '0;
            bytn   <= '0;
            shreg  <= '0;
            idx    <= '0;
            cur    <= '0;
            abort  <= 1'b0;
            scl    <= 1'b1;
            sda_oe <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
            error  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    scl    <= 1'b1;
                    sda_oe <= 1'b0;
                    if (start) begin
                        busy  <= 1'b1;
                        done  <= 1'b0;
                        error <= 1'b0;
                        abort <= 1'b0;
                        idx   <= '0;
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (idx == LAST_IDX ||
                        (entry.idx == END_MARK && entry.val == END_MARK)) begin
                        done  <= 1'b1;
                        busy  <= 1'b0;
                        state <= ST_IDLE;
                    end else begin
                        cur   <= entry;
                        phase <= '0;
                        state <= ST_START;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        phase <= phase + 1'b1;
                        case (phase)
                            2'd0: sda_oe <= 1'b1;
                            2'd2: scl    <= 1'b0;
                            2'd3: begin
                                bitn  <= '0;
                                bytn  <= '0;
                                shreg <= DEV_ADDR;
                                state <= ST_BIT;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_BIT: begin
                    if (tick) begin
                        phase <= phase + 1'b1;
                        case (phase)
                            2'd0: sda_oe <= (bitn == 4'd8) ? 1'b0 : ~shreg[7];
                            2'd1: scl    <= 1'b1;
                            2'd2: if (bitn == 4'd8) abort <= sda_s;
                            default: begin
                                scl <= 1'b0;
                                if (bitn != 4'd8) begin
                                    shreg <= {shreg[6:0], 1'b0};
                                    bitn  <= bitn + 1'b1;
                                end else if (abort || bytn == 2'd2) begin
                                    state <= ST_STOP;
                                end else begin
                                    bitn  <= '0;
                                    bytn  <= bytn + 1'b1;
                                    shreg <= (bytn == 2'd0) ? cur.idx : cur.val;
                                end
                            end
                        endcase
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        phase <= phase + 1'b1;
                        case (phase)
                            2'd0: sda_oe <= 1'b1;
                            2'd1: scl    <= 1'b1;
                            2'd2: sda_oe <= 1'b0;
                            default: begin
                                if (abort) begin
                                    error <= 1'b1;
                                    busy  <= 1'b0;
                                    state <= ST_IDLE;
                                end else begin
                                    idx   <= idx + 1'b1;
                                    state <= ST_LOAD;
                                end
                            end
                        endcase
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scfg_checker.sv
// Protocol and status checks for the table loader, bound to the top.
module scfg_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic scl,
    input logic sda_oe,
    input logic busy,
    input logic done,
    input logic error
);
    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl && !sda_oe));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R8
    done_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R7
    start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && $past(scl) && $rose(sda_oe)) |-> busy);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({done, error}));
endmodule

bind sensor_cfg_master scfg_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .scl    (scl),
    .sda_oe (sda_oe),
    .busy   (busy),
    .done   (done),
    .error  (error)
);

// File: tb/sim_sensor_cfg_master.sv
module sim_sensor_cfg_master;
    localparam int LIVE = 4;
    localparam int Q    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl, sda_oe, busy, done, error;
    logic slave_pull = 1'b0;
    logic sda_w;

    assign sda_w = !(sda_oe || slave_pull);

    always #10 clk = ~clk;

    sensor_cfg_master #(
        .CLK_HZ(50_000_000), .SCL_HZ(2_500_000), .DEV_ADDR(8'h42),
        .DEPTH(8), .LIVE(LIVE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .scl(scl),
        .sda_oe(sda_oe), .sda_in(sda_w), .busy(busy), .done(done), .error(error)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int starts, stops, nack_t, nack_b, bitc, bytec, hi_cnt, lo_cnt, min_hi, min_lo;
    logic in_ack, prev_scl, prev_sda;
    logic [7:0] shift;
    logic [7:0] rx [0:7][0:2];
    int nbytes [0:7];

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bench slave: decodes the bus and acknowledges unless told to refuse
    initial begin
        prev_scl = 1'b1; prev_sda = 1'b1; in_ack = 1'b0; bitc = 0; bytec = 0;
        shift = '0; starts = 0; stops = 0; hi_cnt = 0; lo_cnt = 0;
        min_hi = 1000; min_lo = 1000; nack_t = -1; nack_b = -1;
    end

    always @(negedge clk) begin
        cyc++;
        if (scl) hi_cnt++; else lo_cnt++;
        if (scl && prev_scl && prev_sda && !sda_w) begin
            starts++; bitc = 0; bytec = 0; in_ack = 1'b0;
        end else if (scl && prev_scl && !prev_sda && sda_w) begin
            stops++;
        end else if (scl && !prev_scl) begin
            if (lo_cnt < min_lo) min_lo = lo_cnt;
            if (!in_ack && bitc < 8) begin
                shift = {shift[6:0], sda_w}; bitc++;
            end
        end else if (!scl && prev_scl) begin
            if (hi_cnt < min_hi) min_hi = hi_cnt;
            if (in_ack) begin
                slave_pull = 1'b0; in_ack = 1'b0; bitc = 0; bytec++;
            end else if (bitc == 8 && starts > 0 && starts <= 8 && bytec < 3) begin
                rx[starts-1][bytec] = shift;
                nbytes[starts-1] = bytec + 1;
                slave_pull = !(nack_t == starts - 1 && nack_b == bytec);
                in_ack = 1'b1;
            end
        end
        if (scl && !prev_scl) lo_cnt = 0;
        if (!scl && prev_scl) hi_cnt = 0;
        prev_scl = scl;
        prev_sda = sda_w;
    end

    task automatic run(input int t, input int b, input logic poke);
        starts = 0; stops = 0; min_hi = 1000; min_lo = 1000;
        for (int k = 0; k < 8; k++) nbytes[k] = 0;
        nack_t = t; nack_b = b;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", busy, 1);
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        for (int w = 0; w < 20000 && busy; w++) @(negedge clk);
    endtask

    function automatic logic [23:0] exp_frame(input int k);
        return {8'h42, 8'h20 + 8'(k), 8'h5A ^ 8'(k)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl && !sda_oe && !busy && !done && !error, "R1 idle after reset",
            {scl, sda_oe, busy, done, error}, 5'b10000);

        // Clean walk, with a start pulse while busy that must be ignored
        run(-1, -1, 1'b1);
        for (int k = 0; k < LIVE; k++)
            chk({rx[k][0], rx[k][1], rx[k][2]} == exp_frame(k), "R3 R4 frame bytes",
                {rx[k][0], rx[k][1], rx[k][2]}, exp_frame(k));
        chk(starts == LIVE, "R2 R5 start count", starts, LIVE);
        chk(stops == LIVE, "R3 stop count", stops, LIVE);
        chk(done && !error && !busy, "R5 done flags", {busy, done, error}, 3'b010);
        chk(min_hi == 2 * Q, "R6 SCL high width", min_hi, 2 * Q);
        chk(min_lo == 2 * Q, "R6 R7 SCL low width", min_lo, 2 * Q);
        repeat (50) @(negedge clk);
        chk(done && !error && scl && !sda_oe, "R9 done held idle", {done, error}, 2'b10);

        // Refuse each byte of each transaction in turn
        for (int t = 0; t < LIVE; t++) begin
            for (int b = 0; b < 3; b++) begin
                run(t, b, 1'b0);
                chk(error && !done && !busy, "R8 error flags", {busy, done, error}, 3'b001);
                chk(starts == t + 1, "R8 no further transaction", starts, t + 1);
                chk(stops == t + 1, "R8 stop after refusal", stops, t + 1);
                chk(nbytes[t] == b + 1, "R8 no byte after refusal", nbytes[t], b + 1);
                chk(rx[t][b] == exp_frame(t)[23 - 8*b -: 8], "R3 refused byte value",
                    rx[t][b], exp_frame(t)[23 - 8*b -: 8]);
            end
        end
        repeat (40) @(negedge clk);
        chk(error && !done, "R9 error held idle", {done, error}, 2'b01);

        // A new walk after an error clears it
        run(-1, -1, 1'b0);
        chk(done && !error && starts == LIVE, "R2 R5 walk after error", starts, LIVE);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cyc > 150000);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule